// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host-side bit engine of a two-wire debug port. It accepts one register access at a time over a valid/ready command channel. The command selects the access port or the debug port, sets the direction, and gives a two-bit register address and 32 bits of write data. The engine then generates the serial clock, drives the data line, and hands the line to the target for the windows where the target answers. Each finished command produces one response: the acknowledge code that was received, the read data, and error flags. A second command type sends the line-reset pattern.

The serial clock comes from the system clock through a programmable half-period divider and stays low between operations. All fields go out least-significant bit first. The host changes the data line together with the falling clock edge and samples it at the rising edge. Idle clocks can follow a transfer: a programmable count after access-port transfers, and a fixed minimum after a command flagged as the last of a burst. The command channel accepts a new command only when the engine is idle and no response is waiting. A response stays on its pins, unchanged, until the consumer takes it with `rsp_ready`, so a slow consumer holds back the next command.

Top module: `swd_host_engine`

## Requirements
- R1: Every access begins with 8 bits driven with `swdio_oe`=1, in this order: 1, ap, rnw, addr[0], addr[1], the XOR of ap, rnw, addr[0] and addr[1], 0, 1.
- R2: One serial bit lasts 2*(`cfg_half`+1) system cycles, half with `swclk` low and half with it high. `swdio_o` and `swdio_oe` change only when `swclk` falls or when a command is accepted, and `swclk` stays low whenever no command is in progress.
- R3: For a read with acknowledge OK, `swdio_oe` is 0 for the 38 bits after the header. The engine takes bit 0 as a turnaround, bits 1..3 as the acknowledge, bits 4..35 as data (LSB first) and bit 36 as parity, then leaves one more turnaround bit released.
- R4: For a write with acknowledge OK, `swdio_oe` is 0 for 5 bits (turnaround, 3 acknowledge bits, turnaround). Then the engine drives the 32 data bits LSB first, followed by their even parity (the XOR of all data bits).
- R5: The acknowledge is assembled with the first received bit in `rsp_ack`[0]. Only 3'b001 counts as OK. For any other code, the engine leaves one released turnaround bit after the acknowledge and then goes on to the trailer. It reports `rsp_err`=1 and `rsp_rdata`=0.
- R6: When the received parity bit of an OK read differs from the XOR of the 32 data bits, the response has `rsp_perr`=1, `rsp_err`=1 and `rsp_rdata`=0. When they match, the response has `rsp_rdata` equal to the data, `rsp_perr`=0 and `rsp_err`=0.
- R7: After an access with `cmd_ap`=1, the engine clocks `cfg_ap_idle` idle bits with `swdio_oe`=1 and `swdio_o`=0. The count is taken when the command is accepted. A debug-port access adds no such bits.
- R8: A command with `cmd_last`=1 adds 8 more idle bits (`swdio_oe`=1, `swdio_o`=0) to its trailer, on top of the bits from R7.
- R9: A command with `cmd_lreset`=1 drives 50 ones and then 2 zeros with `swdio_oe`=1 and nothing else. Its response has `rsp_ack`=0, `rsp_err`=0, `rsp_perr`=0 and `rsp_rdata`=0.
- R10: `cmd_ready` is 1 only when the engine is idle. While idle, the line rests with `swclk`=0, `swdio_oe`=1 and `swdio_o`=0. A raised `rsp_valid` and the response fields hold steady until `rsp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | DIV_W | Serial clock half-period minus one, in system cycles |
| cfg_ap_idle | input | AP_IDLE_W | Idle bits after an access-port transfer |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this cycle when valid |
| cmd_lreset | input | 1 | Send the line-reset pattern instead of an access |
| cmd_ap | input | 1 | 1 = access port, 0 = debug port |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | 32 | Write data |
| cmd_last | input | 1 | Last command of a burst, adds the trailing idle bits |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed on this cycle when valid |
| rsp_ack | output | 3 | Received acknowledge code |
| rsp_rdata | output | 32 | Read data, zero unless delivered |
| rsp_perr | output | 1 | Read parity mismatch |
| rsp_err | output | 1 | Access failed (acknowledge or parity) |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Data line value when driven |
| swdio_oe | output | 1 | Data line driver enable |
| swdio_i | input | 1 | Data line as seen by the host |

## Verification
The checker assumes that `cfg_half` and `cfg_ap_idle` do not change while a command is in progress. It also assumes that `swdio_i` is stable at each edge where the engine raises `swclk`. The bench changes the configuration only between commands, when the engine is idle. Its target model advances the bit it presents one cycle after each rising serial edge, so the value is steady for at least a full cycle before the next sampling edge. The bench takes responses either at once or after a few stalled cycles, so the hold rule is exercised both ways.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HDR,
    S_ACK,
    S_RDAT,
    S_TRN,
    S_WDAT,
    S_TAIL,
    S_LRST,
    S_RESP
  } swd_state_e;

  localparam int          DATA_W = 32;
  localparam logic [2:0]  ACK_OK = 3'b001;

  // request byte, bit 0 goes out first
  function automatic logic [7:0] swd_header(input logic ap, input logic rnw,
                                            input logic [1:0] addr);
    logic par;
    par = ap ^ rnw ^ addr[0] ^ addr[1];
    return {1'b1, 1'b0, par, addr[1], addr[0], rnw, ap, 1'b1};
  endfunction

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             swclk,
  output logic             rise,
  output logic             bit_end
);

  logic [DIV_W-1:0] cnt_q;
  logic             lvl_q;
  logic             phase_done;

  assign phase_done = (cnt_q >= half);
  assign rise       = run && !lvl_q && phase_done;
  assign bit_end    = run &&  lvl_q && phase_done;
  assign swclk      = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (phase_done) begin
      cnt_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/swd_rx_check.sv
module swd_rx_check
  import swd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_ack,
  input  logic [1:0]        cap_idx,
  input  logic              cap_dat,
  input  logic              cap_par,
  input  logic              din,
  input  logic              rnw,
  input  logic              lreset,
  output logic              ack_ok,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_perr,
  output logic              rsp_err
);

  logic [2:0]        ack_q;
  logic [DATA_W-1:0] dat_q;
  logic              par_q;
  logic              deliver;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
      dat_q <= '0;
      par_q <= 1'b0;
    end else if (clr) begin
      ack_q <= '0;
      dat_q <= '0;
      par_q <= 1'b0;
    end else begin
      if (cap_ack) ack_q[cap_idx] <= din;
      if (cap_dat) dat_q <= {din, dat_q[DATA_W-1:1]};
      if (cap_par) par_q <= din;
    end
  end

  assign ack_ok    = (ack_q == ACK_OK);
  assign rsp_ack   = ack_q;
  assign rsp_perr  = !lreset && rnw && ack_ok && (par_q != ^dat_q);
  assign rsp_err   = !lreset && (!ack_ok || rsp_perr);
  assign deliver   = !lreset && rnw && ack_ok && !rsp_perr;
  assign rsp_rdata = deliver ? dat_q : '0;

endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_pkg::*;
#(
  parameter int AP_IDLE_W = 8,
  parameter int LAST_IDLE = 8,
  parameter int RST_ONES  = 50,
  parameter int RST_ZEROS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AP_IDLE_W-1:0] cfg_ap_idle,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_lreset,
  input  logic                 cmd_ap,
  input  logic                 cmd_rnw,
  input  logic [1:0]           cmd_addr,
  input  logic [DATA_W-1:0]    cmd_wdata,
  input  logic                 cmd_last,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  input  logic                 rise,
  input  logic                 bit_end,
  input  logic                 ack_ok,
  output logic                 run,
  output logic                 swdio_o,
  output logic                 swdio_oe,
  output logic                 cap_clr,
  output logic                 cap_ack,
  output logic [1:0]           cap_idx,
  output logic                 cap_dat,
  output logic                 cap_par,
  output logic                 acc_rnw,
  output logic                 acc_lreset
);

  localparam int RST_LEN  = RST_ONES + RST_ZEROS;
  localparam int IDLE_MAX = (1 << AP_IDLE_W) - 1 + LAST_IDLE;
  localparam int MAX_A    = (IDLE_MAX > RST_LEN) ? IDLE_MAX : RST_LEN;
  localparam int CNT_MAX  = (MAX_A > DATA_W + 1) ? MAX_A : DATA_W + 1;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ACK = CNT_W'(3);
  localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_RST = CNT_W'(RST_LEN - 1);
  localparam logic [CNT_W-1:0] N_ONES   = CNT_W'(RST_ONES);

  swd_state_e        st_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [CNT_W-1:0]  idle_n_q;
  logic [7:0]        hdr_q;
  logic [DATA_W-1:0] wdat_q;
  logic              rnw_q;
  logic              lreset_q;
  logic              take;
  logic              wpar;
  swd_state_e        tail_next;

  assign take      = (st_q == S_IDLE) && cmd_valid;
  assign wpar      = ^wdat_q;
  assign tail_next = (idle_n_q == '0) ? S_RESP : S_TAIL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      bcnt_q   <= '0;
      idle_n_q <= '0;
      hdr_q    <= '0;
      wdat_q   <= '0;
      rnw_q    <= 1'b0;
      lreset_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (take) begin
            bcnt_q   <= '0;
            hdr_q    <= swd_header(cmd_ap, cmd_rnw, cmd_addr);
            wdat_q   <= cmd_wdata;
            rnw_q    <= cmd_rnw;
            lreset_q <= cmd_lreset;
            idle_n_q <= (cmd_ap   ? CNT_W'(cfg_ap_idle) : '0) +
                        (cmd_last ? CNT_W'(LAST_IDLE)   : '0);
            st_q     <= cmd_lreset ? S_LRST : S_HDR;
          end
        end
        S_HDR: begin
          if (bit_end) begin
            if (bcnt_q == LAST_HDR) begin
              bcnt_q <= '0;
              st_q   <= S_ACK;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        S_ACK: begin
          if (bit_end) begin
            if (bcnt_q == LAST_ACK) begin
              bcnt_q <= '0;
              st_q   <= (ack_ok && rnw_q) ? S_RDAT : S_TRN;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        S_RDAT: begin
          if (bit_end) begin
            if (bcnt_q == LAST_DAT) begin
              bcnt_q <= '0;
              st_q   <= S_TRN;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        S_TRN: begin
          if (bit_end) begin
            bcnt_q <= '0;
            st_q   <= (ack_ok && !rnw_q) ? S_WDAT : tail_next;
          end
        end
        S_WDAT: begin
          if (bit_end) begin
            if (bcnt_q == LAST_DAT) begin
              bcnt_q <= '0;
              st_q   <= tail_next;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        S_TAIL: begin
          if (bit_end) begin
            if (bcnt_q == idle_n_q - 1'b1) begin
              bcnt_q <= '0;
              st_q   <= S_RESP;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        S_LRST: begin
          if (bit_end) begin
            if (bcnt_q == LAST_RST) begin
              bcnt_q <= '0;
              st_q   <= S_RESP;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        S_RESP: begin
          if (rsp_ready) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      S_HDR:   swdio_o = hdr_q[bcnt_q[2:0]];
      S_WDAT:  swdio_o = (bcnt_q < LAST_DAT) ? wdat_q[bcnt_q[4:0]] : wpar;
      S_LRST:  swdio_o = (bcnt_q < N_ONES);
      default: swdio_o = 1'b0;
    endcase
  end

  assign swdio_oe   = !((st_q == S_ACK) || (st_q == S_RDAT) || (st_q == S_TRN));
  assign cmd_ready  = (st_q == S_IDLE);
  assign rsp_valid  = (st_q == S_RESP);
  assign run        = (st_q != S_IDLE) && (st_q != S_RESP);

  assign cap_clr    = take;
  assign cap_ack    = rise && (st_q == S_ACK) && (bcnt_q != '0);
  assign cap_idx    = bcnt_q[1:0] - 2'd1;
  assign cap_dat    = rise && (st_q == S_RDAT) && (bcnt_q < LAST_DAT);
  assign cap_par    = rise && (st_q == S_RDAT) && (bcnt_q == LAST_DAT);
  assign acc_rnw    = rnw_q;
  assign acc_lreset = lreset_q;

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int AP_IDLE_W = 8,
  parameter int LAST_IDLE = 8,
  parameter int RST_ONES  = 50,
  parameter int RST_ZEROS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     cfg_half,
  input  logic [AP_IDLE_W-1:0] cfg_ap_idle,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_lreset,
  input  logic                 cmd_ap,
  input  logic                 cmd_rnw,
  input  logic [1:0]           cmd_addr,
  input  logic [31:0]          cmd_wdata,
  input  logic                 cmd_last,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [2:0]           rsp_ack,
  output logic [31:0]          rsp_rdata,
  output logic                 rsp_perr,
  output logic                 rsp_err,
  output logic                 swclk,
  output logic                 swdio_o,
  output logic                 swdio_oe,
  input  logic                 swdio_i
);

  logic       run, rise, bit_end, ack_ok;
  logic       cap_clr, cap_ack, cap_dat, cap_par;
  logic [1:0] cap_idx;
  logic       acc_rnw, acc_lreset;

  swd_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .half    (cfg_half),
    .swclk   (swclk),
    .rise    (rise),
    .bit_end (bit_end)
  );

  swd_seq #(
    .AP_IDLE_W (AP_IDLE_W),
    .LAST_IDLE (LAST_IDLE),
    .RST_ONES  (RST_ONES),
    .RST_ZEROS (RST_ZEROS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ap_idle (cfg_ap_idle),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_lreset  (cmd_lreset),
    .cmd_ap      (cmd_ap),
    .cmd_rnw     (cmd_rnw),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .cmd_last    (cmd_last),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rise        (rise),
    .bit_end     (bit_end),
    .ack_ok      (ack_ok),
    .run         (run),
    .swdio_o     (swdio_o),
    .swdio_oe    (swdio_oe),
    .cap_clr     (cap_clr),
    .cap_ack     (cap_ack),
    .cap_idx     (cap_idx),
    .cap_dat     (cap_dat),
    .cap_par     (cap_par),
    .acc_rnw     (acc_rnw),
    .acc_lreset  (acc_lreset)
  );

  swd_rx_check u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cap_clr),
    .cap_ack   (cap_ack),
    .cap_idx   (cap_idx),
    .cap_dat   (cap_dat),
    .cap_par   (cap_par),
    .din       (swdio_i),
    .rnw       (acc_rnw),
    .lreset    (acc_lreset),
    .ack_ok    (ack_ok),
    .rsp_ack   (rsp_ack),
    .rsp_rdata (rsp_rdata),
    .rsp_perr  (rsp_perr),
    .rsp_err   (rsp_err)
  );

endmodule

// File: rtl/swd_host_chk.sv
module swd_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [2:0]  rsp_ack,
  input logic [31:0] rsp_rdata,
  input logic        rsp_perr,
  input logic        rsp_err,
  input logic        swclk,
  input logic        swdio_o,
  input logic        swdio_oe
);

  // R2: line only moves while the serial clock is low
  a_r2_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    swclk |-> ($stable(swdio_o) && $stable(swdio_oe)));

  // R2: clock parked low while a response waits
  a_r2_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !swclk);

  // R10: idle line state whenever a command can be taken
  a_r10_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!swclk && swdio_oe && !swdio_o && !rsp_valid));

  // R10: response held under back-pressure
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ack) &&
      $stable(rsp_rdata) && $stable(rsp_err) && $stable(rsp_perr)));

  // R6: parity failure withholds data
  a_r6_perr_withheld: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perr) |-> (rsp_err && (rsp_rdata == 32'd0)));

  // R5: refused access withholds data
  a_r5_nack_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_ack != 3'b001) && (rsp_ack != 3'b000)) |->
      (rsp_err && (rsp_rdata == 32'd0)));

endmodule

bind swd_host_engine swd_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_ack   (rsp_ack),
  .rsp_rdata (rsp_rdata),
  .rsp_perr  (rsp_perr),
  .rsp_err   (rsp_err),
  .swclk     (swclk),
  .swdio_o   (swdio_o),
  .swdio_oe  (swdio_oe)
);

// File: tb/tb_swd_host_engine.sv
`timescale 1ns/1ps
module tb_swd_host_engine;

  localparam int N_ONES  = 50;
  localparam int N_ZEROS = 2;
  localparam int LAST_N  = 8;
  localparam int LOG_N   = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_half = '0;
  logic [7:0]  cfg_ap_idle = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_lreset = 1'b0;
  logic        cmd_ap = 1'b0;
  logic        cmd_rnw = 1'b0;
  logic [1:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_last = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;
  logic        rsp_perr;
  logic        rsp_err;
  logic        swclk;
  logic        swdio_o;
  logic        swdio_oe;
  logic        swdio_i;

  always #2 clk = ~clk;

  swd_host_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_ap_idle(cfg_ap_idle),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_lreset(cmd_lreset),
    .cmd_ap(cmd_ap), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_last(cmd_last), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rsp_perr(rsp_perr), .rsp_err(rsp_err), .swclk(swclk),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  logic tgt [0:127];
  logic rec_d [0:LOG_N-1];
  logic rec_oe [0:LOG_N-1];
  int   nbits = 0;
  int   since = 0;
  int   pmin = 0;
  int   pmax = 0;
  bit   pvalid = 1'b0;
  logic swclk_q = 1'b0;

  assign swdio_i = (nbits < 128) ? tgt[nbits] : 1'b0;

  // target side: records each rising serial edge
  always @(negedge clk) begin
    since = since + 1;
    if (swclk && !swclk_q) begin
      if (nbits < LOG_N) begin
        rec_d[nbits]  = swdio_o;
        rec_oe[nbits] = swdio_oe;
      end
      nbits = nbits + 1;
      if (pvalid) begin
        if (since < pmin) pmin = since;
        if (since > pmax) pmax = since;
      end
      pvalid = 1'b1;
      since  = 0;
    end
    swclk_q = swclk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_cmd(input bit lrst, input bit ap, input bit rnw,
                         input logic [1:0] addr, input logic [31:0] wd,
                         input bit last, input logic [2:0] ack,
                         input logic [31:0] rd, input bit flip,
                         input int apidle, input int half, input bit bp,
                         input string tag);
    logic e_d [0:LOG_N-1];
    logic e_oe [0:LOG_N-1];
    int   n = 0;
    int   guard = 0;
    int   bad_at = -1;
    bit   ackok;
    int   idle_n;
    logic [2:0]  s_ack;
    logic [31:0] s_rd;
    logic        s_err, s_perr;
    logic [2:0]  x_ack;
    logic [31:0] x_rd;
    logic        x_err, x_perr;

    @(negedge clk);
    rsp_ready = 1'b0;
    // R10: line at rest between commands
    check(cmd_ready && !swclk && swdio_oe && !swdio_o, "R10", "idle line",
          {swclk, swdio_oe, swdio_o}, 3'b010);
    cfg_half    = 8'(half);
    cfg_ap_idle = 8'(apidle);
    for (int i = 0; i < 128; i++) tgt[i] = 1'b0;
    for (int i = 0; i < 3; i++) tgt[9 + i] = ack[i];
    if (rnw) begin
      for (int i = 0; i < 32; i++) tgt[12 + i] = rd[i];
      tgt[44] = (^rd) ^ flip;
    end
    nbits = 0; pvalid = 1'b0; pmin = 1000000; pmax = 0;
    cmd_lreset = lrst; cmd_ap = ap; cmd_rnw = rnw; cmd_addr = addr;
    cmd_wdata = wd; cmd_last = last; cmd_valid = 1'b1;
    if (!bp) rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(rsp_valid, tag, "response timeout", 0, 1);

    s_ack = rsp_ack; s_rd = rsp_rdata; s_err = rsp_err; s_perr = rsp_perr;
    if (bp) begin
      repeat (4) @(negedge clk);
      check(rsp_valid && rsp_ack == s_ack && rsp_rdata == s_rd &&
            rsp_err == s_err && rsp_perr == s_perr, "R10", "held response",
            rsp_rdata, s_rd);
      rsp_ready = 1'b1;
    end

    // expected line activity
    ackok = (ack == 3'b001);
    if (lrst) begin
      for (int i = 0; i < N_ONES + N_ZEROS; i++) begin
        e_d[n] = (i < N_ONES); e_oe[n] = 1'b1; n++;
      end
    end else begin
      e_d[0] = 1'b1; e_d[1] = ap; e_d[2] = rnw; e_d[3] = addr[0];
      e_d[4] = addr[1]; e_d[5] = ap ^ rnw ^ addr[0] ^ addr[1];
      e_d[6] = 1'b0; e_d[7] = 1'b1;
      for (int i = 0; i < 8; i++) e_oe[i] = 1'b1;
      n = 8;
      if (ackok && rnw) begin
        for (int i = 0; i < 38; i++) begin e_d[n] = 1'b0; e_oe[n] = 1'b0; n++; end
      end else begin
        for (int i = 0; i < 5; i++) begin e_d[n] = 1'b0; e_oe[n] = 1'b0; n++; end
        if (ackok) begin
          for (int i = 0; i < 32; i++) begin e_d[n] = wd[i]; e_oe[n] = 1'b1; n++; end
          e_d[n] = ^wd; e_oe[n] = 1'b1; n++;
        end
      end
      idle_n = (ap ? apidle : 0) + (last ? LAST_N : 0);
      for (int i = 0; i < idle_n; i++) begin e_d[n] = 1'b0; e_oe[n] = 1'b1; n++; end

      for (int i = 0; i < 8; i++)
        if (bad_at < 0 && (rec_d[i] !== e_d[i] || rec_oe[i] !== 1'b1)) bad_at = i;
      check(bad_at < 0, "R1", "header bit", bad_at, -1);
    end

    bad_at = -1;
    for (int i = 0; i < n && i < nbits && i < LOG_N; i++)
      if (bad_at < 0 && (rec_oe[i] !== e_oe[i] || (e_oe[i] && rec_d[i] !== e_d[i])))
        bad_at = i;
    check(nbits == n, tag, "bit count", nbits, n);
    check(bad_at < 0, tag, "line bit index", bad_at, -1);
    check(pmin == 2 * (half + 1) && pmax == 2 * (half + 1), "R2", "bit period",
          {pmin[15:0], pmax[15:0]}, {16'(2 * (half + 1)), 16'(2 * (half + 1))});

    // expected response
    if (lrst) begin
      x_ack = 3'b000; x_perr = 1'b0; x_err = 1'b0; x_rd = '0;
    end else begin
      x_ack  = ack;
      x_perr = ackok && rnw && flip;
      x_err  = !ackok || x_perr;
      x_rd   = (ackok && rnw && !flip) ? rd : 32'd0;
    end
    check(s_ack == x_ack, tag, "rsp_ack", s_ack, x_ack);
    check(s_rd == x_rd, tag, "rsp_rdata", s_rd, x_rd);
    check(s_err == x_err && s_perr == x_perr, tag, "rsp_err/perr",
          {s_err, s_perr}, {x_err, x_perr});
    @(posedge clk);
  endtask

  initial begin
    #(4 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    int k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 / R2: state after reset
    check(cmd_ready && !rsp_valid, "R10", "reset handshake",
          {cmd_ready, rsp_valid}, 2'b10);
    check(!swclk && swdio_oe && !swdio_o, "R2", "reset line",
          {swclk, swdio_oe, swdio_o}, 3'b010);

    // R3 / R4 / R1 / R7: every header over three clock rates
    for (int h = 0; h < 3; h++)
      for (int a = 0; a < 2; a++)
        for (int r = 0; r < 2; r++)
          for (int ad = 0; ad < 4; ad++) begin
            k++;
            run_cmd(1'b0, a[0], r[0], ad[1:0], 32'hC3A5_0F96 ^ (32'h0101_0101 * k),
                    1'b0, 3'b001, 32'h9E37_79B9 * k, 1'b0, 2, h,
                    1'b0, r[0] ? "R3" : "R4");
          end

    // R5: refused or garbled acknowledge on reads and writes
    for (int r = 0; r < 2; r++) begin
      run_cmd(1'b0, 1'b0, r[0], 2'd1, 32'h1234_5678, 1'b0, 3'b010,
              32'hFFFF_0000, 1'b0, 0, 1, 1'b0, "R5");
      run_cmd(1'b0, 1'b1, r[0], 2'd2, 32'h8765_4321, 1'b0, 3'b100,
              32'h0F0F_F0F0, 1'b0, 3, 0, 1'b0, "R5");
      run_cmd(1'b0, 1'b0, r[0], 2'd3, 32'hDEAD_BEEF, 1'b1, 3'b111,
              32'h5555_AAAA, 1'b0, 0, 0, 1'b0, "R5");
      run_cmd(1'b0, 1'b0, r[0], 2'd0, 32'h0000_0001, 1'b0, 3'b000,
              32'h1111_1111, 1'b0, 0, 2, 1'b0, "R5");
    end

    // R6: parity mismatch and match at data extremes
    run_cmd(1'b0, 1'b0, 1'b1, 2'd0, 32'h0, 1'b0, 3'b001, 32'h8000_0001,
            1'b1, 0, 0, 1'b0, "R6");
    run_cmd(1'b0, 1'b1, 1'b1, 2'd3, 32'h0, 1'b0, 3'b001, 32'hFFFF_FFFF,
            1'b1, 0, 1, 1'b0, "R6");
    run_cmd(1'b0, 1'b0, 1'b1, 2'd2, 32'h0, 1'b0, 3'b001, 32'h0000_0000,
            1'b0, 0, 0, 1'b0, "R6");
    run_cmd(1'b0, 1'b0, 1'b1, 2'd2, 32'h0, 1'b0, 3'b001, 32'h7FFF_FFFF,
            1'b0, 0, 0, 1'b0, "R6");

    // R7: idle count range, and none for debug-port accesses
    run_cmd(1'b0, 1'b1, 1'b0, 2'd1, 32'hA5A5_5A5A, 1'b0, 3'b001, 32'h0,
            1'b0, 0, 0, 1'b0, "R7");
    run_cmd(1'b0, 1'b1, 1'b1, 2'd1, 32'h0, 1'b0, 3'b001, 32'h2468_ACE0,
            1'b0, 255, 0, 1'b0, "R7");
    run_cmd(1'b0, 1'b0, 1'b0, 2'd1, 32'h1357_9BDF, 1'b0, 3'b001, 32'h0,
            1'b0, 9, 0, 1'b0, "R7");

    // R8: burst end with and without access-port idle
    run_cmd(1'b0, 1'b0, 1'b0, 2'd2, 32'hCAFE_F00D, 1'b1, 3'b001, 32'h0,
            1'b0, 7, 1, 1'b0, "R8");
    run_cmd(1'b0, 1'b1, 1'b1, 2'd3, 32'h0, 1'b1, 3'b001, 32'hB00B_1E55,
            1'b0, 4, 0, 1'b0, "R8");

    // R9: line reset, once with back-pressure (R10)
    run_cmd(1'b1, 1'b1, 1'b1, 2'd3, 32'hFFFF_FFFF, 1'b1, 3'b111, 32'hFFFF_FFFF,
            1'b0, 5, 0, 1'b0, "R9");
    run_cmd(1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 3'b001, 32'h0,
            1'b0, 0, 2, 1'b1, "R9");

    // R10: stalled response on a read
    run_cmd(1'b0, 1'b1, 1'b1, 2'd0, 32'h0, 1'b0, 3'b001, 32'h0BAD_CAFE,
            1'b0, 1, 1, 1'b1, "R10");

    @(negedge clk);
    finish_run();
  end

endmodule